// File: doc/BRIEF.md
# Predicated Integer ALU with Status Flags

This block executes one 32-bit data-processing operation per clock, gated by a 4-bit predicate code. The predicate is tested against the stored negative, zero, carry and overflow flags. When it holds, the operation runs. Its result may be written to a destination register, and its flags may be updated. When the predicate fails, the operation leaves no trace: nothing is written, the flags keep their value and the result output holds.

Operand A comes from a register. Operand B arrives already prepared by an external shifter, together with that shifter's carry-out. The opcode picks one of sixteen operations: logical, arithmetic with and without carry-in, forward and reverse subtraction, and four compare/test forms. The compare/test forms exist only to set flags. Result, write-enable and flags are registered, so an operation issued in one cycle is predicated on the flags left by the operation issued in the cycle before.

Top module: `cx_alu_core`

## Requirements
- R1: While reset is held, and right after it, the result is zero, the write-enable is low and all four flags are clear.
- R2: The predicate codes are tested against the flags as follows.
  - 0000: Z set. 0001: Z clear.
  - 0010: C set. 0011: C clear.
  - 0100: N set. 0101: N clear.
  - 0110: V set. 0111: V clear.
  - 1000: C set and Z clear. 1001: the opposite of 1000.
  - 1010: N equals V. 1011: N differs from V.
  - 1100: Z clear and N equals V. 1101: the opposite of 1100.
- R3: Code 1110 always executes. Code 1111 never executes: no write and no flag change.
- R4: When the predicate fails, the write-enable is low and the flags are unchanged.
- R5: The logical opcodes and their results are:
  - 0000: A AND B.
  - 0001: A XOR B.
  - 1100: A OR B.
  - 1101: B.
  - 1110: A AND NOT B.
  - 1111: NOT B.
- R6: The arithmetic opcodes, with Cf the stored carry flag, are:
  - 0010: A−B.
  - 0011: B−A.
  - 0100: A+B.
  - 0101: A+B+Cf.
  - 0110: A+NOT B+Cf.
  - 0111: B+NOT A+Cf.
- R7: Opcodes 1000 (AND), 1001 (XOR), 1010 (A−B) and 1011 (A+B) update the flags whenever they execute, regardless of the set-flags request, and never assert the write-enable.
- R8: Any other opcode changes the flags only when the set-flags request is high.
- R9: For arithmetic, C is the adder carry-out, which for subtraction means C=1 when no borrow occurs. V is signed overflow.
- R10: For logical operations, C takes the shifter carry input and V is kept. For all operations, N is result bit 31 and Z is set for a zero result.
- R11: The outputs appear on the clock edge after the inputs. An operation predicated on flags sees the flags written by the immediately preceding operation.
- R12: When the write-enable is low, the result output holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 4 | Predicate code |
| opcode_i | input | 4 | Operation select |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Prepared operand B |
| shift_carry_i | input | 1 | Carry-out of the operand B shifter |
| set_flags_i | input | 1 | Request to update flags |
| result_o | output | 32 | Registered result |
| rd_we_o | output | 1 | Destination write-enable |
| flags_o | output | 4 | Flags {N,Z,C,V} |

## Verification
Two things can land in the same cycle: the flag write of one operation and the predicate test of the next. The bench provokes this by issuing a compare, then immediately issuing all sixteen predicate codes on a move, for five operand pairs. Those pairs leave distinct flag patterns. A behavioural model checks, every clock, that each predicate saw the freshly written flags and not stale ones. Carry-consuming operations issued right after a flag-setting add or subtract stress the same path through the carry flag.

// File: rtl/cx_alu_pkg.sv
package cx_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/cx_cond_eval.sv
module cx_cond_eval
    import cx_alu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       pass_o
);
    // Odd codes are the complement of the even code below them;
    // 111x maps to always, and its complement is never.
    logic base;

    always_comb begin
        unique case (cond_i[3:1])
            3'b000:  base = flags_i.z;
            3'b001:  base = flags_i.c;
            3'b010:  base = flags_i.n;
            3'b011:  base = flags_i.v;
            3'b100:  base = flags_i.c & ~flags_i.z;
            3'b101:  base = (flags_i.n == flags_i.v);
            3'b110:  base = ~flags_i.z & (flags_i.n == flags_i.v);
            default: base = 1'b1;
        endcase
        pass_o = base ^ cond_i[0];
    end
endmodule

// File: rtl/cx_dp_unit.sv
module cx_dp_unit
    import cx_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              shift_carry_i,
    input  flags_t            flags_i,
    output logic [DATA_W-1:0] result_o,
    output flags_t            flags_o,
    output logic              flag_only_o
);
    localparam int MSB = DATA_W - 1;

    alu_op_e           op;
    logic [DATA_W-1:0] add_x, add_y, logic_res;
    logic              add_cin, is_arith;
    logic [DATA_W:0]   sum;

    assign op          = alu_op_e'(opcode_i);
    assign flag_only_o = (opcode_i[3:2] == 2'b10);

    always_comb begin
        add_x    = opa_i;
        add_y    = opb_i;
        add_cin  = 1'b0;
        is_arith = 1'b1;
        unique case (op)
            OP_SUB, OP_CMP: begin add_y = ~opb_i; add_cin = 1'b1; end
            OP_RSB:         begin add_x = opb_i; add_y = ~opa_i; add_cin = 1'b1; end
            OP_ADD, OP_CMN: add_cin = 1'b0;
            OP_ADC:         add_cin = flags_i.c;
            OP_SBC:         begin add_y = ~opb_i; add_cin = flags_i.c; end
            OP_RSC:         begin add_x = opb_i; add_y = ~opa_i; add_cin = flags_i.c; end
            default:        is_arith = 1'b0;
        endcase
        sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_cin};
    end

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: logic_res = opa_i & opb_i;
            OP_EOR, OP_TEQ: logic_res = opa_i ^ opb_i;
            OP_ORR:         logic_res = opa_i | opb_i;
            OP_MOV:         logic_res = opb_i;
            OP_BIC:         logic_res = opa_i & ~opb_i;
            OP_MVN:         logic_res = ~opb_i;
            default:        logic_res = '0;
        endcase
    end

    always_comb begin
        result_o  = is_arith ? sum[MSB:0] : logic_res;
        flags_o.n = result_o[MSB];
        flags_o.z = (result_o == '0);
        flags_o.c = is_arith ? sum[DATA_W] : shift_carry_i;
        flags_o.v = is_arith ? ((add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]))
                             : flags_i.v;
    end
endmodule

// File: rtl/cx_alu_core.sv
module cx_alu_core
    import cx_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cond_i,
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              shift_carry_i,
    input  logic              set_flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              rd_we_o,
    output logic [3:0]        flags_o
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              we;
        flags_t            flags;
    } state_t;

    state_t            st_d, st_q;
    logic              pass;
    logic              flag_only;
    logic [DATA_W-1:0] dp_res;
    flags_t            dp_flags;

    cx_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (st_q.flags),
        .pass_o  (pass)
    );

    cx_dp_unit #(.DATA_W(DATA_W)) u_dp (
        .opcode_i      (opcode_i),
        .opa_i         (opa_i),
        .opb_i         (opb_i),
        .shift_carry_i (shift_carry_i),
        .flags_i       (st_q.flags),
        .result_o      (dp_res),
        .flags_o       (dp_flags),
        .flag_only_o   (flag_only)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = pass && !flag_only;
        if (pass && !flag_only) begin
            st_d.result = dp_res;
        end
        if (pass && (set_flags_i || flag_only)) begin
            st_d.flags = dp_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign rd_we_o  = st_q.we;
    assign flags_o  = st_q.flags;
endmodule

// File: rtl/cx_alu_checker.sv
module cx_alu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cond_i,
    input logic [3:0]        opcode_i,
    input logic              set_flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic              rd_we_o,
    input logic [3:0]        flags_o
);
    logic flag_only, is_logic;
    assign flag_only = (opcode_i[3:2] == 2'b10);
    assign is_logic  = (opcode_i[3:1] == 3'b000) || (opcode_i[3:1] == 3'b100)
                     || (opcode_i[3:2] == 2'b11);

    p_never_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i == 4'hF |=> !rd_we_o && flags_o == $past(flags_o));

    p_always_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'hE && !flag_only) |=> rd_we_o);

    p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_only |=> !rd_we_o);

    p_noset_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_only && !set_flags_i) |=> flags_o == $past(flags_o));

    p_logic_keeps_v_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> flags_o[0] == $past(flags_o[0]));

    p_hold_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_we_o |-> result_o == $past(result_o));
endmodule

bind cx_alu_core cx_alu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cx_alu_core_bench.sv
`timescale 1ns/1ps
module cx_alu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond_i = 4'hE, opcode_i = 4'hD;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic        shift_carry_i = 1'b0, set_flags_i = 1'b0;
    logic [31:0] result_o;
    logic        rd_we_o;
    logic [3:0]  flags_o;

    int checks = 0, failures = 0;
    logic [31:0] m_res = '0;
    logic        m_we = 1'b0;
    logic [3:0]  m_fl = 4'h0; // {N,Z,C,V}

    always #2 clk = ~clk;

    cx_alu_core u_cx_alu_core (.*);

    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v, r;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'h0: r = z;            4'h1: r = !z;
            4'h2: r = cy;           4'h3: r = !cy;
            4'h4: r = n;            4'h5: r = !n;
            4'h6: r = v;            4'h7: r = !v;
            4'h8: r = cy && !z;     4'h9: r = !(cy && !z);
            4'hA: r = n == v;       4'hB: r = n != v;
            4'hC: r = !z && n == v; 4'hD: r = !(!z && n == v);
            4'hE: r = 1'b1;         default: r = 1'b0;
        endcase
        return r;
    endfunction

    task automatic check_out(input string tag);
        checks++;
        if (result_o !== m_res || rd_we_o !== m_we || flags_o !== m_fl) begin
            failures++;
            $display("FAIL %s: got res=%h we=%b fl=%b, expected res=%h we=%b fl=%b",
                     tag, result_o, rd_we_o, flags_o, m_res, m_we, m_fl);
        end
    endtask

    task automatic run(input logic [3:0] c, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic sc, input logic sf, input string tag);
        logic [31:0] x, y, r;
        logic cin, arith, cmp, pass, cy, v;
        longint u, s;
        @(negedge clk);
        cond_i = c; opcode_i = op; opa_i = a; opb_i = b; shift_carry_i = sc; set_flags_i = sf;
        arith = 1'b1; x = a; y = b; cin = 1'b0; r = '0;
        case (op)
            4'h2, 4'hA: begin y = ~b; cin = 1'b1; end
            4'h3: begin x = b; y = ~a; cin = 1'b1; end
            4'h4, 4'hB: cin = 1'b0;
            4'h5: cin = m_fl[1];
            4'h6: begin y = ~b; cin = m_fl[1]; end
            4'h7: begin x = b; y = ~a; cin = m_fl[1]; end
            default: arith = 1'b0;
        endcase
        u = longint'({32'b0, x}) + longint'({32'b0, y}) + longint'(cin);
        s = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
        case (op)
            4'h0, 4'h8: r = a & b;
            4'h1, 4'h9: r = a ^ b;
            4'hC: r = a | b;
            4'hD: r = b;
            4'hE: r = a & ~b;
            4'hF: r = ~b;
            default: r = u[31:0];
        endcase
        cy = arith ? u[32] : sc;
        v  = arith ? (s > 64'sd2147483647 || s < -64'sd2147483648) : m_fl[0];
        cmp  = (op >= 4'h8 && op <= 4'hB);
        pass = cond_ok(c, m_fl);
        m_we = pass && !cmp;
        if (pass && !cmp) m_res = r;
        if (pass && (sf || cmp)) m_fl = {r[31], r == 32'h0, cy, v};
        @(posedge clk);
        #1;
        check_out(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_out("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        // R5 R10: move of zero with flags, shifter carry to C
        run(4'hE, 4'hD, 32'h0, 32'h0, 1'b1, 1'b1, "R5 R10 MOV zero");
        // R9: signed overflow, carry clear
        run(4'hE, 4'h4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1, "R9 ADD overflow");
        // R9: carry out to zero
        run(4'hE, 4'h4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, "R9 ADD carry zero");
        // R6 R11: ADC consumes carry just set
        run(4'hE, 4'h5, 32'h10, 32'h20, 1'b0, 1'b1, "R6 R11 ADC carry in");
        run(4'hE, 4'h2, 32'd5, 32'd3, 1'b0, 1'b1, "R9 SUB no borrow");
        run(4'hE, 4'h2, 32'd3, 32'd5, 1'b0, 1'b1, "R9 SUB borrow");
        run(4'hE, 4'h6, 32'd100, 32'd1, 1'b0, 1'b1, "R6 SBC after borrow");
        run(4'hE, 4'h3, 32'd7, 32'd20, 1'b0, 1'b1, "R6 RSB");
        run(4'hE, 4'h7, 32'd7, 32'd20, 1'b0, 1'b1, "R6 RSC");
        run(4'hE, 4'h7, 32'd9, 32'd3, 1'b0, 1'b0, "R6 RSC no flags");
        // R7 R12: compare sets flags, no write, result held
        run(4'hE, 4'hA, 32'd42, 32'd42, 1'b0, 1'b0, "R7 R12 CMP equal");
        run(4'hE, 4'hB, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, "R7 CMN");
        // R11 R4: back-to-back predicate on fresh flags
        run(4'h0, 4'h4, 32'd1, 32'd2, 1'b0, 1'b0, "R11 EQ after CMN");
        run(4'h1, 4'h4, 32'd1, 32'd2, 1'b0, 1'b1, "R4 NE fails");
        // R2 R3: every predicate against five flag patterns
        for (int p = 0; p < 5; p++) begin
            logic [31:0] pa, pb;
            case (p)
                0: begin pa = 32'd5;         pb = 32'd5;         end
                1: begin pa = 32'd3;         pb = 32'd5;         end
                2: begin pa = 32'd5;         pb = 32'd3;         end
                3: begin pa = 32'h8000_0000; pb = 32'h1;         end
                default: begin pa = 32'h7FFF_FFFF; pb = 32'hFFFF_FFFF; end
            endcase
            run(4'hE, 4'hA, pa, pb, 1'b0, 1'b0, "R7 CMP set pattern");
            for (int c = 0; c < 16; c++) begin
                run(4'(c), 4'hD, 32'h0, 32'(100 + 16 * p + c), 1'b0, 1'b0, "R2 R3 predicate");
            end
        end
        // R5 R10: logical operations with flags
        run(4'hE, 4'h0, 32'hF0F0_1234, 32'h8F00_FF00, 1'b1, 1'b1, "R5 R10 AND");
        run(4'hE, 4'h1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 1'b1, "R5 R10 EOR zero");
        run(4'hE, 4'hC, 32'h0000_00F0, 32'h8000_000F, 1'b1, 1'b1, "R5 ORR");
        run(4'hE, 4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b1, "R5 BIC");
        run(4'hE, 4'hF, 32'h0, 32'h0, 1'b1, 1'b1, "R5 MVN");
        // R10: V kept across logical op after an overflow
        run(4'hE, 4'h4, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R9 ADD neg overflow");
        run(4'hE, 4'hD, 32'h0, 32'h1, 1'b0, 1'b1, "R10 MOV keeps V");
        run(4'hE, 4'h8, 32'h1, 32'h2, 1'b1, 1'b0, "R7 TST no write");
        run(4'hE, 4'h9, 32'h5, 32'h4, 1'b0, 1'b0, "R7 TEQ");
        // R8: no set request leaves flags
        run(4'hE, 4'h4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, "R8 ADD no flags");
        run(4'hE, 4'hF, 32'h0, 32'h0, 1'b0, 1'b0, "R8 MVN no flags");
        // R3 R4: never code with compare and with flag request
        run(4'hF, 4'hA, 32'd1, 32'd1, 1'b0, 1'b0, "R3 NV CMP");
        run(4'hF, 4'h4, 32'd1, 32'd1, 1'b1, 1'b1, "R3 R12 NV ADD");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule